// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block is a watchdog timer. It advances on a strobe from a separate low-power oscillator, nominally 31.25 kHz, and does not depend on the main clock rate. While it is enabled, software has to clear it at regular intervals. If software stops doing so, the count reaches a selected limit and the watchdog times out. The limit is always a power of two of oscillator ticks.

The action on a timeout depends on the power state of the device. When the device is running normally, the block raises a reset request and holds it for a fixed number of clock cycles. When the device is in sleep or idle, it does not reset anything. It sends a one-cycle non-maskable interrupt and a one-cycle wake pulse, and it sets a sticky status flag. That flag lets software tell afterwards that a power-save timeout took place. A watchdog reset does not clear the flag. Only a write-one-to-clear strobe or the asynchronous block reset clears it.

Top module: `wdt_top`

## Requirements
- R1: During and right after the asynchronous reset, `rst_req_o`, `nmi_o`, `wake_o` and `to_stat_o` are all low.
- R2: While `en_i` is low, the count stays at zero and no timeout can occur. After `en_i` goes high again, a full period must pass before a timeout.
- R3: With the select value `s` on `sel_i`, a timeout happens on the tick that finds the count at or above 2^(s+1)-1. The count then returns to zero, so successive timeouts are 2^(s+1) ticks apart.
- R4: A timeout while `sleep_i` and `idle_i` are both low drives `rst_req_o` high for exactly RST_CYC cycles, starting the cycle after the timeout. This does not change `to_stat_o`.
- R5: A timeout while `sleep_i` or `idle_i` is high drives `nmi_o` and `wake_o` high for exactly one cycle, starting the cycle after the timeout. In this case `rst_req_o` stays low.
- R6: A power-save timeout sets `to_stat_o`. The flag stays high until `st_clr_i` is high at a clock edge. If a set and a clear land on the same edge, the set wins. A watchdog reset request does not clear the flag.
- R7: While `rst_req_o` is high, the count is held at zero and ticks are ignored. The next timeout therefore needs a full 2^(s+1) ticks after the request ends.
- R8: A high `kick_i` clears the count at the next edge, and it takes priority over a tick in the same cycle. Clearing more often than once per period prevents any timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_tick_i | input | 1 | One-cycle strobe per low-power oscillator period, already synchronised to `clk_i` |
| en_i | input | 1 | Watchdog enable |
| kick_i | input | 1 | Software clear strobe |
| sleep_i | input | 1 | Device is in sleep |
| idle_i | input | 1 | Device is in idle |
| sel_i | input | SEL_W | Period select; the period is 2^(sel_i+1) ticks |
| st_clr_i | input | 1 | Write-one-to-clear for the timeout status flag |
| rst_req_o | output | 1 | Device reset request, held RST_CYC cycles |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| wake_o | output | 1 | Wake request pulse |
| to_stat_o | output | 1 | Sticky power-save timeout flag |

## Verification
The assertions assume that `lp_tick_i` arrives as a strobe already synchronised to `clk_i`, and that every input changes only between clock edges. The one-cycle NMI property also depends on the fact that any period needs at least two ticks, so two timeouts can never fall on adjacent cycles. The stimulus keeps to these conditions. It produces a tick every fourth clock from a dedicated generator and changes all other inputs on the falling edge. Power-state and select changes are made only between timeouts, apart from the deliberate clear that overlaps a power-save timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RESET = 2'd1,
    ACT_NMI   = 2'd2
  } wdt_act_e;
endpackage

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             to_o,
  output logic             cnt_zero_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             run;

  // limit = 2^(sel+1)-1 as a thermometer mask
  for (genvar g = 0; g < CNT_W; g++) begin : g_lim
    assign lim[g] = (sel_i >= SEL_W'(g));
  end

  assign run        = en_i & ~clr_i & ~hold_i;
  assign to_o       = run & tick_i & (cnt_q >= lim);
  assign cnt_zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick_i)  cnt_q <= to_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_act.sv
module wdt_act
  import wdt_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wdt_act_e act_i,
  input  logic     st_clr_i,
  output logic     rst_req_o,
  output logic     nmi_o,
  output logic     wake_o,
  output logic     stat_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [RC_W-1:0] rc_q;
  logic            nmi_q, wake_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q   <= '0;
      nmi_q  <= 1'b0;
      wake_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      nmi_q  <= (act_i == ACT_NMI);
      wake_q <= (act_i == ACT_NMI);
      if (act_i == ACT_NMI) stat_q <= 1'b1;
      else if (st_clr_i)    stat_q <= 1'b0;
      if (act_i == ACT_RESET) rc_q <= RC_W'(RST_CYC);
      else if (rc_q != '0)    rc_q <= rc_q - 1'b1;
    end
  end

  assign rst_req_o = (rc_q != '0);
  assign nmi_o     = nmi_q;
  assign wake_o    = wake_q;
  assign stat_o    = stat_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int RST_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_tick_i,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic             sleep_i,
  input  logic             idle_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             st_clr_i,
  output logic             rst_req_o,
  output logic             nmi_o,
  output logic             wake_o,
  output logic             to_stat_o
);
  logic     to;
  logic     cnt_zero;
  wdt_act_e act;

  wdt_cnt #(.SEL_W(SEL_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .clr_i      (kick_i),
    .hold_i     (rst_req_o),
    .tick_i     (lp_tick_i),
    .sel_i      (sel_i),
    .to_o       (to),
    .cnt_zero_o (cnt_zero)
  );

  always_comb begin
    act = ACT_NONE;
    if (to) act = (sleep_i | idle_i) ? ACT_NMI : ACT_RESET;
  end

  wdt_act #(.RST_CYC(RST_CYC)) i_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .st_clr_i  (st_clr_i),
    .rst_req_o (rst_req_o),
    .nmi_o     (nmi_o),
    .wake_o    (wake_o),
    .stat_o    (to_stat_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int RST_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_req_o,
  input logic nmi_o,
  input logic to_stat_o,
  input logic st_clr_i,
  input logic cnt_zero_i
);
  localparam int HL_W = $clog2(RST_CYC + 2);

  logic [HL_W-1:0] hi_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_len_q <= '0;
    else if (rst_req_o) hi_len_q <= hi_len_q + 1'b1;
    else                hi_len_q <= '0;
  end

  p_rst_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (hi_len_q < HL_W'(RST_CYC)));

  p_rst_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (hi_len_q == HL_W'(RST_CYC)));

  p_nmi_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> !rst_req_o);

  p_nmi_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o);

  p_stat_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_stat_o) |-> nmi_o);

  p_stat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_stat_o && !st_clr_i) |=> to_stat_o);

  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> cnt_zero_i);
endmodule

bind wdt_top wdt_chk #(.RST_CYC(RST_CYC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_req_o  (rst_req_o),
  .nmi_o      (nmi_o),
  .to_stat_o  (to_stat_o),
  .st_clr_i   (st_clr_i),
  .cnt_zero_i (cnt_zero)
);

// File: tb/test_wdt_top.sv
`timescale 1ns/1ps
module test_wdt_top;
  localparam int SEL_W   = 4;
  localparam int RST_CYC = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, en = 1'b0, kick = 1'b0;
  logic sleep = 1'b0, idle = 1'b0, st_clr = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic rst_req, nmi, wake, stat;

  wdt_top #(.SEL_W(SEL_W), .RST_CYC(RST_CYC)) i_wdt_top (
    .clk_i(clk), .rst_ni(rst_n), .lp_tick_i(tick), .en_i(en), .kick_i(kick),
    .sleep_i(sleep), .idle_i(idle), .sel_i(sel), .st_clr_i(st_clr),
    .rst_req_o(rst_req), .nmi_o(nmi), .wake_o(wake), .to_stat_o(stat)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // tick generator: one strobe every fourth clock
  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      tick = (tdiv == 3);
      tdiv = (tdiv + 1) % 4;
    end
  end

  // behavioural reference model
  int m_cnt = 0, m_left = 0, m_lim;
  bit m_nmi = 0, m_wake = 0, m_stat = 0, m_hold, m_to;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_left = 0; m_nmi = 0; m_wake = 0; m_stat = 0;
    end else begin
      m_hold = (m_left > 0);
      m_to   = 0;
      m_lim  = (1 << (int'(sel) + 1)) - 1;
      if (m_left > 0) m_left--;
      m_nmi = 0; m_wake = 0;
      if (!en || kick || m_hold) m_cnt = 0;
      else if (tick) begin
        if (m_cnt >= m_lim) begin m_to = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (m_to && (sleep || idle)) begin
        m_nmi = 1; m_wake = 1; m_stat = 1;
      end else begin
        if (m_to) m_left = RST_CYC;
        if (st_clr) m_stat = 0;
      end
    end
  end

  // tick counter and event monitors
  int tk = 0, ev_rst = 0, ev_nmi = 0;
  bit p_rst = 0, p_nmi = 0;
  always @(posedge clk) if (tick) tk++;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rst_req == (m_left > 0), "R4 rst_req", int'(rst_req), int'(m_left > 0));
      chk(nmi == m_nmi, "R5 nmi", int'(nmi), int'(m_nmi));
      chk(wake == m_wake, "R5 wake", int'(wake), int'(m_wake));
      chk(stat == m_stat, "R6 stat", int'(stat), int'(m_stat));
      if (rst_req && !p_rst) ev_rst++;
      if (nmi && !p_nmi) ev_nmi++;
      p_rst = rst_req;
      p_nmi = nmi;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  task automatic wait_rise_rst();
    @(negedge clk);
    while (!rst_req) @(negedge clk);
  endtask

  task automatic wait_nmi();
    @(negedge clk);
    while (!nmi) @(negedge clk);
  endtask

  initial begin
    int n, t1, t2, e0, e1;
    repeat (3) @(negedge clk);
    chk({rst_req, nmi, wake, stat} == 4'b0, "R1 in reset", int'({rst_req, nmi, wake, stat}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rst_req, nmi, wake, stat} == 4'b0, "R1 after reset", int'({rst_req, nmi, wake, stat}), 0);

    // R4: run-mode timeout gives a reset of RST_CYC cycles
    sel = 4'd1; en = 1'b1;
    wait_rise_rst();
    n = 0;
    while (rst_req) begin n++; @(negedge clk); end
    chk(n == RST_CYC, "R4 reset width", n, RST_CYC);
    chk(stat == 1'b0, "R4 status untouched", int'(stat), 0);

    // R7: after the request ends a full period is needed
    t1 = tk;
    wait_rise_rst();
    t2 = tk;
    chk(t2 - t1 == 4, "R7 ticks ignored during hold", t2 - t1, 4);
    while (rst_req) @(negedge clk);
    en = 1'b0;

    // R5/R3: sleep timeout, NMI and wake pulses, period check
    @(negedge clk);
    sleep = 1'b1; sel = 4'd2; en = 1'b1;
    wait_nmi();
    t1 = tk;
    chk(wake == 1'b1, "R5 wake with nmi", int'(wake), 1);
    chk(rst_req == 1'b0, "R5 no reset in sleep", int'(rst_req), 0);
    @(negedge clk);
    chk(nmi == 1'b0, "R5 nmi one cycle", int'(nmi), 0);
    chk(stat == 1'b1, "R6 status set", int'(stat), 1);
    wait_nmi();
    t2 = tk;
    chk(t2 - t1 == 8, "R3 period 2^(s+1)", t2 - t1, 8);

    // R6: a watchdog reset keeps the flag
    sleep = 1'b0;
    wait_rise_rst();
    while (rst_req) @(negedge clk);
    chk(stat == 1'b1, "R6 kept over reset", int'(stat), 1);
    st_clr = 1'b1;
    @(negedge clk);
    st_clr = 1'b0;
    chk(stat == 1'b0, "R6 w1c", int'(stat), 0);

    // R6: set wins over a simultaneous clear (idle mode)
    idle = 1'b1; st_clr = 1'b1;
    wait_nmi();
    chk(stat == 1'b1, "R6 set wins", int'(stat), 1);
    @(negedge clk);
    chk(stat == 1'b0, "R6 clear next", int'(stat), 0);
    st_clr = 1'b0; idle = 1'b0;

    // R8: regular kicks prevent any timeout
    while (rst_req) @(negedge clk);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    e0 = ev_rst + ev_nmi;
    for (int i = 0; i < 40; i++) begin
      repeat (6) @(negedge clk);
      kick = 1'b1; @(negedge clk); kick = 1'b0;
    end
    e1 = ev_rst + ev_nmi;
    chk(e1 == e0, "R8 kicked no timeout", e1 - e0, 0);

    // R2: disabled watchdog never times out
    en = 1'b0; sel = 4'd0;
    repeat (300) @(negedge clk);
    chk(ev_rst + ev_nmi == e1, "R2 disabled no timeout", ev_rst + ev_nmi - e1, 0);
    t1 = tk; en = 1'b1;
    wait_rise_rst();
    t2 = tk;
    chk(t2 - t1 == 2, "R2 full period after enable", t2 - t1, 2);
    while (rst_req) @(negedge clk);

    // R3: longer period
    en = 1'b0; @(negedge clk);
    sel = 4'd5; sleep = 1'b1; t1 = tk; en = 1'b1;
    wait_nmi();
    t2 = tk;
    chk(t2 - t1 == 64, "R3 long period", t2 - t1, 64);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule